// File: doc/BRIEF.md
# Two-Wire EEPROM Boot Configuration Loader

This block runs by itself as soon as hardware reset is released. It fetches a nine-byte configuration image from an optional serial EEPROM on a two-wire open-drain bus. First it does a dummy write that sets the EEPROM's internal pointer to byte zero. Then it issues a repeated start and reads the image back with one sequential read. The same sequence also tells the block whether an EEPROM is fitted. If no device answers its address, the block concludes that none is present.

The first byte of the image is a header. It must match a constant set by parameter. The next eight bytes form two 32-bit words: a subsystem identifier word and a general configuration word. The block writes both words to its output registers in the same cycle, and only after all nine bytes have arrived and the header has matched. In every other outcome the reset defaults stay in place and the abort flag is raised. Either way, a single-cycle done pulse marks the end of the sequence.

Top module: `eepromBootLoader`

## Requirements
- R1: While reset is held, both bus drive-enables are low (lines released) and done, valid and abort are low. After reset is released, the first bus event is a START, with no other input needed.
- R2: The data line changes only while the clock line is low, except for the START and STOP conditions. A successful load produces exactly two STARTs (the first start and the repeated start) and one STOP.
- R3: The dummy write sends address byte 0xA0 (device address 7'b1010000 followed by a write bit of 0), then word address 0x00.
- R4: After the repeated start, the block sends address byte 0xA1 (same device address, read bit 1), then reads exactly nine bytes in sequence.
- R5: The block drives ACK (data line low) in the acknowledge slot of received bytes 1 to 8. It leaves a NACK (line released) after byte 9, then issues STOP.
- R6: If byte 0 equals HEADER (default 0x55), the block loads subsysWord = {byte4,byte3,byte2,byte1} and cfgWord = {byte8,byte7,byte6,byte5}. Both words change only in the cycle in which done is high.
- R7: If byte 0 differs from HEADER, both words keep their reset defaults and abort is raised after the nine bytes have been read.
- R8: A NACK to the write address, the word address or the read address makes the block issue STOP, read no data bytes, raise abort and keep the defaults.
- R9: Done is high for exactly one cycle per reset. In that cycle exactly one of valid or abort is high.
- R10: Valid (after a successful load) and abort (after a failure) each stay high until the next reset, and never both.
- R11: Within a byte, one clock-line period is 4*QTR_CYCLES cycles. Each data-line change made by the block while the clock line is low comes QTR_CYCLES cycles after the clock line fell, which is the midpoint of the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sdaIn | input | 1 | Sampled level of the data line |
| sclDrvLow | output | 1 | Pull the clock line low when 1, release when 0 |
| sdaDrvLow | output | 1 | Pull the data line low when 1, release when 0 |
| subsysWord | output | 32 | Loaded subsystem identifier word (default DEF_SUBSYS) |
| cfgWord | output | 32 | Loaded general configuration word (default DEF_CFG) |
| loadDone | output | 1 | One-cycle pulse at the end of the sequence |
| loadValid | output | 1 | Image loaded successfully; held until reset |
| loadAbort | output | 1 | Sequence aborted; held until reset |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that sdaIn is the resolved open-drain level of the data line, so the block sees its own low drive reflected back. The bench meets both assumptions. It holds reset from time zero and builds the data line as the wired-AND of the block's drive and a behavioural EEPROM responder. That responder changes the data line only just after the clock line falls. This gives the block's sample point, half way through the high phase, a settled value. Random images and headers come from a seeded generator. Directed cases add an all-zero image, an all-ones image, and a NACK at each of the three address phases.

// File: rtl/eeBootPkg.sv
package eeBootPkg;

  // Number of bytes fetched from the EEPROM: header plus two 32-bit words.
  localparam int IMG_BYTES = 9;

  // Bus symbol that the datapath plays out on request.
  typedef enum logic [1:0] {
    SYM_START = 2'd0,
    SYM_STOP  = 2'd1,
    SYM_TX    = 2'd2,  // 8 data bits out, ack sampled in slot 8
    SYM_RX    = 2'd3   // 8 data bits in, ack/nack driven in slot 8
  } symKind_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       go;      // launch one symbol
    symKind_t   kind;
    logic [7:0] txByte;
    logic       lastRx;  // leave NACK after this received byte
    logic       commit;  // copy assembled image into output words
  } eeStrobe_t;

endpackage

// File: rtl/eeBootDatapath.sv
module eeBootDatapath
  import eeBootPkg::*;
#(
  parameter int          QTR_CYCLES = 4,
  parameter logic [7:0]  HEADER     = 8'h55,
  parameter logic [31:0] DEF_SUBSYS = 32'h1234_0001,
  parameter logic [31:0] DEF_CFG    = 32'h0000_00A5
) (
  input  logic        clk,
  input  logic        rstN,
  input  eeStrobe_t   strobe,
  input  logic        sdaIn,
  output logic        symDone,
  output logic        ackOk,
  output logic        headerOk,
  output logic        sclDrvLow,
  output logic        sdaDrvLow,
  output logic [31:0] subsysWord,
  output logic [31:0] cfgWord
);

  localparam int QW    = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam int IMG_W = IMG_BYTES * 8;
  localparam logic [QW-1:0] QLAST = QW'(QTR_CYCLES - 1);

  logic            busy;
  logic [QW-1:0]   qCnt;
  logic [1:0]      quarter;
  logic [3:0]      slot;
  symKind_t        kindR;
  logic [7:0]      txShift;
  logic [7:0]      rxShift;
  logic            lastRxR;
  logic            ackOkR;
  logic            sclLowR;
  logic            sdaLowR;
  logic [IMG_W-1:0] img;
  logic [31:0]     subsysR;
  logic [31:0]     cfgR;

  logic qTick;
  logic lastSlot;
  logic sdaNext;

  assign qTick    = busy && (qCnt == QLAST);
  assign lastSlot = (kindR == SYM_START || kindR == SYM_STOP) ? (slot == 4'd0) : (slot == 4'd8);
  assign symDone  = qTick && (quarter == 2'd3) && lastSlot;

  // Level placed on the data line at the midpoint of the clock-low phase.
  always_comb begin
    unique case (kindR)
      SYM_START: sdaNext = 1'b0;
      SYM_STOP:  sdaNext = 1'b1;
      SYM_TX:    sdaNext = (slot < 4'd8) ? !txShift[3'd7 - slot[2:0]] : 1'b0;
      default:   sdaNext = (slot < 4'd8) ? 1'b0 : !lastRxR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      qCnt    <= '0;
      quarter <= 2'd0;
      slot    <= 4'd0;
      kindR   <= SYM_START;
      txShift <= 8'h00;
      rxShift <= 8'h00;
      lastRxR <= 1'b0;
      ackOkR  <= 1'b0;
      sclLowR <= 1'b0;
      sdaLowR <= 1'b0;
    end else if (strobe.go) begin
      busy    <= 1'b1;
      qCnt    <= '0;
      quarter <= 2'd0;
      slot    <= 4'd0;
      kindR   <= strobe.kind;
      txShift <= strobe.txByte;
      lastRxR <= strobe.lastRx;
      sclLowR <= 1'b1;
    end else if (busy) begin
      if (qTick) begin
        qCnt    <= '0;
        quarter <= quarter + 2'd1;
        unique case (quarter)
          2'd0: sdaLowR <= sdaNext;
          2'd1: sclLowR <= 1'b0;
          2'd2: begin
            if (kindR == SYM_TX && slot == 4'd8) ackOkR <= !sdaIn;
            if (kindR == SYM_RX && slot < 4'd8)  rxShift <= {rxShift[6:0], sdaIn};
            if (kindR == SYM_START) sdaLowR <= 1'b1;
            if (kindR == SYM_STOP)  sdaLowR <= 1'b0;
          end
          default: begin
            if (lastSlot) begin
              busy <= 1'b0;
            end else begin
              slot    <= slot + 4'd1;
              sclLowR <= 1'b1;
            end
          end
        endcase
      end else begin
        qCnt <= qCnt + QW'(1);
      end
    end
  end

  // Image assembly and commit of the output words.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      img     <= '0;
      subsysR <= DEF_SUBSYS;
      cfgR    <= DEF_CFG;
    end else begin
      if (symDone && kindR == SYM_RX) img <= {rxShift, img[IMG_W-1:8]};
      if (strobe.commit) begin
        subsysR <= img[39:8];
        cfgR    <= img[71:40];
      end
    end
  end

  assign ackOk      = ackOkR;
  assign headerOk   = (img[7:0] == HEADER);
  assign sclDrvLow  = sclLowR;
  assign sdaDrvLow  = sdaLowR;
  assign subsysWord = subsysR;
  assign cfgWord    = cfgR;

endmodule

// File: rtl/eeBootCtrl.sv
module eeBootCtrl
  import eeBootPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      symDone,
  input  logic      ackOk,
  input  logic      headerOk,
  output eeStrobe_t strobe,
  output logic      loadDone,
  output logic      loadValid,
  output logic      loadAbort
);

  localparam int CW = $clog2(IMG_BYTES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(IMG_BYTES - 1);

  typedef enum logic [3:0] {
    ST_BOOT_START, ST_DEV_WR, ST_WORD_ADDR, ST_RESTART,
    ST_DEV_RD, ST_READ, ST_STOP, ST_FINISH, ST_HALT
  } ctlState_t;

  ctlState_t     state;
  logic          pending;
  logic          failed;
  logic [CW-1:0] rxCount;
  logic          doneR;
  logic          validR;
  logic          abortR;
  logic          busState;

  assign busState = (state != ST_FINISH) && (state != ST_HALT);

  always_comb begin
    strobe        = '0;
    strobe.go     = busState && !pending;
    strobe.kind   = SYM_START;
    unique case (state)
      ST_DEV_WR:    begin strobe.kind = SYM_TX; strobe.txByte = {DEV_ADDR, 1'b0}; end
      ST_WORD_ADDR: begin strobe.kind = SYM_TX; strobe.txByte = 8'h00; end
      ST_DEV_RD:    begin strobe.kind = SYM_TX; strobe.txByte = {DEV_ADDR, 1'b1}; end
      ST_READ:      begin strobe.kind = SYM_RX; strobe.lastRx = (rxCount == LAST_IDX); end
      ST_STOP:      strobe.kind = SYM_STOP;
      default:      strobe.kind = SYM_START;
    endcase
    strobe.commit = (state == ST_FINISH) && !failed && headerOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_BOOT_START;
      pending <= 1'b0;
      failed  <= 1'b0;
      rxCount <= '0;
      doneR   <= 1'b0;
      validR  <= 1'b0;
      abortR  <= 1'b0;
    end else begin
      if (strobe.go) pending <= 1'b1;
      if (symDone) begin
        pending <= 1'b0;
        unique case (state)
          ST_BOOT_START: state <= ST_DEV_WR;
          ST_DEV_WR:     if (ackOk) state <= ST_WORD_ADDR; else begin failed <= 1'b1; state <= ST_STOP; end
          ST_WORD_ADDR:  if (ackOk) state <= ST_RESTART;   else begin failed <= 1'b1; state <= ST_STOP; end
          ST_RESTART:    state <= ST_DEV_RD;
          ST_DEV_RD:     if (ackOk) state <= ST_READ;      else begin failed <= 1'b1; state <= ST_STOP; end
          ST_READ: begin
            rxCount <= rxCount + CW'(1);
            if (rxCount == LAST_IDX) state <= ST_STOP;
          end
          ST_STOP:       state <= ST_FINISH;
          default:       state <= state;
        endcase
      end
      if (state == ST_FINISH) begin
        doneR  <= 1'b1;
        validR <= strobe.commit;
        abortR <= !strobe.commit;
        state  <= ST_HALT;
      end else begin
        doneR <= 1'b0;
      end
    end
  end

  assign loadDone  = doneR;
  assign loadValid = validR;
  assign loadAbort = abortR;

endmodule

// File: rtl/eepromBootLoader.sv
module eepromBootLoader
  import eeBootPkg::*;
#(
  parameter int          QTR_CYCLES = 4,
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter logic [7:0]  HEADER     = 8'h55,
  parameter logic [31:0] DEF_SUBSYS = 32'h1234_0001,
  parameter logic [31:0] DEF_CFG    = 32'h0000_00A5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaIn,
  output logic        sclDrvLow,
  output logic        sdaDrvLow,
  output logic [31:0] subsysWord,
  output logic [31:0] cfgWord,
  output logic        loadDone,
  output logic        loadValid,
  output logic        loadAbort
);

  eeStrobe_t strobe;
  logic      symDone;
  logic      ackOk;
  logic      headerOk;

  eeBootCtrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .symDone(symDone), .ackOk(ackOk), .headerOk(headerOk),
    .strobe(strobe), .loadDone(loadDone), .loadValid(loadValid), .loadAbort(loadAbort)
  );

  eeBootDatapath #(
    .QTR_CYCLES(QTR_CYCLES), .HEADER(HEADER), .DEF_SUBSYS(DEF_SUBSYS), .DEF_CFG(DEF_CFG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaIn(sdaIn),
    .symDone(symDone), .ackOk(ackOk), .headerOk(headerOk),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .subsysWord(subsysWord), .cfgWord(cfgWord)
  );

endmodule

// File: rtl/eepromBootLoaderChk.sv
module eepromBootLoaderChk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] subsysWord,
  input logic [31:0] cfgWord,
  input logic        loadDone,
  input logic        loadValid,
  input logic        loadAbort
);

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);  // R9

  AST_DONE_HAS_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (loadValid ^ loadAbort));  // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(loadValid && loadAbort));  // R10

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> loadValid);  // R10

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    loadAbort |=> loadAbort);  // R10

  AST_WORDS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(subsysWord) || !$stable(cfgWord)) |-> (loadDone && loadValid));  // R6

endmodule

bind eepromBootLoader eepromBootLoaderChk chk_i (
  .clk(clk), .rstN(rstN), .subsysWord(subsysWord), .cfgWord(cfgWord),
  .loadDone(loadDone), .loadValid(loadValid), .loadAbort(loadAbort)
);

// File: tb/eepromBootLoader_tb_top.sv
`timescale 1ns/1ps
module eepromBootLoader_tb_top;

  localparam int          QTR  = 4;
  localparam logic [31:0] DSUB = 32'h1234_0001;
  localparam logic [31:0] DCFG = 32'h0000_00A5;
  localparam logic [7:0]  HDR  = 8'h55;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rstN = 1'b0;
  logic        sclDrvLow, sdaDrvLow, loadDone, loadValid, loadAbort;
  logic [31:0] subsysWord, cfgWord;
  logic        slvLow = 1'b0;
  wire         sclBus = !sclDrvLow;
  wire         sdaBus = !(sdaDrvLow || slvLow);

  eepromBootLoader #(.QTR_CYCLES(QTR), .HEADER(HDR), .DEF_SUBSYS(DSUB), .DEF_CFG(DCFG)) dut_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaBus), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .subsysWord(subsysWord), .cfgWord(cfgWord),
    .loadDone(loadDone), .loadValid(loadValid), .loadAbort(loadAbort)
  );

  int checkCnt = 0;
  int failCnt  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM responder ----------------
  logic [7:0] mem [16];
  int         nackAt = 0;  // 0 none, 1 write addr, 2 word addr, 3 read addr
  logic [7:0] addrLog [4];
  int addrCnt, bytesSent, ackErr, startCnt, stopCnt;
  int bitCnt, mode, rxPhase, ptr;
  logic [7:0] rxb, txb;
  logic pendAck, isRd, prevScl, prevSda, masterAck;

  always @(negedge clk) begin
    logic s, d;
    s = sclBus; d = sdaBus;
    if (!rstN) begin
      slvLow = 1'b0; mode = 0; bitCnt = 0; rxPhase = 0; ptr = 0; addrCnt = 0;
      bytesSent = 0; ackErr = 0; startCnt = 0; stopCnt = 0; prevScl = 1'b1; prevSda = 1'b1;
      pendAck = 1'b0; isRd = 1'b0; rxb = 8'h00; txb = 8'h00; masterAck = 1'b0;
      for (int i = 0; i < 4; i++) addrLog[i] = 8'h00;
    end else begin
      if (prevScl && s && prevSda && !d) begin
        startCnt++; mode = 1; rxPhase = 0; bitCnt = 0; slvLow = 1'b0;
      end else if (prevScl && s && !prevSda && d) begin
        stopCnt++; mode = 0; slvLow = 1'b0;
      end else if (!prevScl && s) begin
        if (mode == 1 && bitCnt < 8) begin rxb = {rxb[6:0], d}; bitCnt++; end
        else if (mode == 2 && bitCnt < 8) bitCnt++;
        else if (mode == 2 && bitCnt == 9) masterAck = !d;
      end else if (prevScl && !s) begin
        if (mode == 1) begin
          if (bitCnt == 8) begin
            if (addrCnt < 4) addrLog[addrCnt] = rxb;
            addrCnt++;
            isRd = (rxb == 8'hA1);
            if (rxPhase == 0) pendAck = (rxb == 8'hA0 && nackAt != 1) || (rxb == 8'hA1 && nackAt != 3);
            else pendAck = (nackAt != 2);
            slvLow = pendAck; bitCnt = 9;
          end else if (bitCnt == 9) begin
            slvLow = 1'b0; bitCnt = 0;
            if (!pendAck) mode = 0;
            else if (rxPhase == 0 && isRd) begin
              mode = 2; txb = mem[ptr[3:0]]; slvLow = !txb[7];
            end else if (rxPhase == 0) rxPhase = 1;
            else begin ptr = int'(rxb); mode = 0; end
          end
        end else if (mode == 2) begin
          if (bitCnt == 8) begin slvLow = 1'b0; bitCnt = 9; end
          else if (bitCnt == 9) begin
            bytesSent++;
            if ((bytesSent < 9 && !masterAck) || (bytesSent >= 9 && masterAck)) ackErr++;
            if (masterAck) begin
              ptr = (ptr + 1) % 16; txb = mem[ptr[3:0]]; slvLow = !txb[7]; bitCnt = 0;
            end else begin slvLow = 1'b0; mode = 0; end
          end else slvLow = !txb[3'd7 - bitCnt[2:0]];
        end
      end
      prevScl = s; prevSda = d;
    end
  end

  // ---------------- timing and done monitor ----------------
  int cyc, lastFall, minInt, offsetErr, doneCnt;
  logic pSclDrv, pSdaDrv;
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; lastFall = -1; minInt = 1000000; offsetErr = 0; doneCnt = 0;
      pSclDrv = 1'b0; pSdaDrv = 1'b0;
    end else begin
      cyc++;
      if (loadDone) doneCnt++;
      if (sclDrvLow && !pSclDrv) begin
        if (lastFall >= 0 && cyc - lastFall < minInt) minInt = cyc - lastFall;
        lastFall = cyc;
      end
      if (sdaDrvLow != pSdaDrv && sclDrvLow && pSclDrv && cyc - lastFall != QTR) offsetErr++;
      pSclDrv = sclDrvLow; pSdaDrv = sdaDrvLow;
    end
  end

  function automatic logic [31:0] expWord(input int base);
    return {mem[base+3], mem[base+2], mem[base+1], mem[base]};
  endfunction

  task automatic runLoad(input int nk, output bit ok);
    int w;
    nackAt = nk;
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sclDrvLow && !sdaDrvLow && !loadDone && !loadValid && !loadAbort && subsysWord == DSUB,
        "R1 reset state", {27'd0, sclDrvLow, sdaDrvLow, loadDone, loadValid, loadAbort}, 32'd0);
    rstN = 1'b1;
    w = 0;
    while (doneCnt == 0 && w < 20000) begin @(negedge clk); w++; end
    ok = (doneCnt != 0);
    if (!ok) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual %0d expected done", w);
      return;
    end
    repeat (40) @(negedge clk);
    chk(doneCnt == 1, "R9 done pulses once", doneCnt, 1);
    chk(!sclDrvLow && !sdaDrvLow, "R1 lines released after load", {sclDrvLow, sdaDrvLow}, 0);
    chk(stopCnt == 1, "R8/R5 one STOP", stopCnt, 1);
    chk(startCnt >= 1 && addrLog[0] == 8'hA0, "R1/R3 start then write address", addrLog[0], 8'hA0);
  endtask

  task automatic runGood(input string what);
    bit ok;
    runLoad(0, ok);
    if (!ok) return;
    chk(subsysWord == expWord(1), {"R6 subsys ", what}, subsysWord, expWord(1));
    chk(cfgWord == expWord(5), {"R6 cfg ", what}, cfgWord, expWord(5));
    chk(loadValid && !loadAbort, "R10 valid only", {loadValid, loadAbort}, 2'b10);
    chk(startCnt == 2, "R2 two STARTs", startCnt, 2);
    chk(addrLog[1] == 8'h00, "R3 word address zero", addrLog[1], 8'h00);
    chk(addrLog[2] == 8'hA1, "R4 read address", addrLog[2], 8'hA1);
    chk(bytesSent == 9, "R4 nine bytes read", bytesSent, 9);
    chk(ackErr == 0, "R5 ack pattern", ackErr, 0);
    chk(minInt == 4 * QTR, "R11 clock period", minInt, 4 * QTR);
    chk(offsetErr == 0, "R11 data change offset", offsetErr, 0);
  endtask

  task automatic fillImage(input logic [7:0] hdr);
    mem[0] = hdr;
    for (int i = 1; i < 16; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd4281));
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;

    for (int n = 0; n < 5; n++) begin fillImage(HDR); runGood("random"); end

    mem[0] = HDR; for (int i = 1; i < 16; i++) mem[i] = 8'hFF; runGood("all ones");
    mem[0] = HDR; for (int i = 1; i < 16; i++) mem[i] = 8'h00; runGood("all zeros");

    for (int n = 0; n < 3; n++) begin
      logic [7:0] h;
      h = 8'($urandom);
      if (h == HDR) h = 8'hAA;
      fillImage(h);
      runLoad(0, ok);
      if (ok) begin
        chk(subsysWord == DSUB && cfgWord == DCFG, "R7 defaults kept", subsysWord, DSUB);
        chk(loadAbort && !loadValid, "R7 abort raised", {loadValid, loadAbort}, 2'b01);
        chk(bytesSent == 9, "R7 image fully read", bytesSent, 9);
      end
    end

    for (int nk = 1; nk <= 3; nk++) begin
      fillImage(HDR);
      runLoad(nk, ok);
      if (ok) begin
        chk(subsysWord == DSUB && cfgWord == DCFG, "R8 defaults kept", cfgWord, DCFG);
        chk(loadAbort && !loadValid, "R8 abort raised", {loadValid, loadAbort}, 2'b01);
        chk(bytesSent == 0, "R8 no data read", bytesSent, 0);
        chk(addrCnt == nk, "R8 stopped at nacked phase", addrCnt, nk);
      end
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule